// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block interprets the write port of a NOR-style flash model. Every clock cycle with `wr_en` high is one bus write, made of an address and a command byte. The block recognises two six-write erase sequences: a whole-array erase, and an erase of selected sectors. The erase itself is a fixed delay that stands in for the embedded pre-program, verify and erase steps.

For a sector erase, the sixth write names the first sector. That write opens a timed acceptance window. Each further sector-erase write during the window adds one sector to the set and restarts the window. Any other write during the window, except suspend, throws the set away. Once the window closes, the erase runs. During the erase only suspend is honoured, and a whole-array erase honours nothing. A suspended erase resumes with the cycles it still has left.

States: `S_IDLE` (read-array mode), `S_KEY1`, `S_KEY2`, `S_ARMED`, `S_KEY3`, `S_KEY4` (prefix writes seen so far), `S_WINDOW`, `S_SECT_ERASE`, `S_CHIP_ERASE`, `S_SUSPEND`.

Transitions:
- The correct next prefix write moves the block one step along the prefix chain.
- A wrong prefix write returns the block to `S_IDLE`.
- From `S_KEY4`, a whole-array erase command goes to `S_CHIP_ERASE`.
- From `S_KEY4`, a sector-erase command goes to `S_WINDOW`. Any other write goes to `S_IDLE`.
- `S_WINDOW` goes to `S_SECT_ERASE` when the window times out.
- `S_WINDOW` goes to `S_SUSPEND` on a suspend write.
- `S_WINDOW` goes to `S_IDLE` on any other write.
- `S_SECT_ERASE` goes to `S_SUSPEND` on a suspend write.
- `S_SUSPEND` goes back to `S_SECT_ERASE` on a resume write.
- `S_SECT_ERASE` and `S_CHIP_ERASE` go to `S_IDLE` when the erase delay expires.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `win_closed`, `suspended` and `sect_mask` are all 0.
- R2: The prefix is five writes, in this order:
  - `wr_addr[10:0]`=0x555, data 0xAA
  - 0x2AA, data 0x55
  - 0x555, data 0x80
  - 0x555, data 0xAA
  - 0x2AA, data 0x55

  Address bits above bit 10 are ignored for these five writes. A sixth write of 0x555/0x10 starts a whole-array erase: `sect_mask` becomes all ones, and `busy` and `win_closed` are 1 for CHIP_CYC cycles starting at that write's edge.
- R3: A sixth write with data 0x30 sets the `sect_mask` bit selected by `wr_addr[ADDR_W-1 -: SECT_W]` and opens the window. While the window is open, `win_closed` and `busy` are 0. With no further write, the window stays open for WIN_CYC cycles starting at that edge.
- R4: While the window is open, a write with data 0x30 adds its sector to the set, in any order and up to all sectors. The same write restarts the window count. A write that lands on the closing edge is still accepted.
- R5: While the window is open, a write with any data other than 0x30 or 0xB0 clears `sect_mask` and returns the block to idle.
- R6: When the window closes, `busy` and `win_closed` go to 1 for ERASE_CYC cycles. After that, all outputs return to 0 and the set is released.
- R7: During a sector erase, any write other than 0xB0 has no effect. During a whole-array erase, every write has no effect, 0xB0 included.
- R8: A write that breaks the prefix returns the block to idle, so a full prefix is needed again. This applies to a wrong address or data at any step, and to a sixth write that is neither 0x10 at 0x555 nor 0x30.
- R9: A 0xB0 write, at any address, during the window or during a sector erase sets `suspended`=1, `busy`=0 and `win_closed`=1, and the set is kept. Writes other than 0x30 are ignored while suspended. A 0x30 write resumes the erase with its remaining cycles, and the window's cycles do not count towards them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One bus write in this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; command in the low byte |
| busy | output | 1 | Erase running |
| win_closed | output | 1 | 0 while the window is open, 1 once erasure has started or is suspended |
| suspended | output | 1 | Sector erase is suspended |
| sect_mask | output | NUM_SECT | Sectors selected for erase |

## Verification
All outputs are decoded from the state register and the set register. Each write's effect therefore shows from the edge that samples it. The bench drives on falling edges and checks on the next falling edge.

Timing is counted from the edge of the last accepted write:
- The window is still open after WIN_CYC-1 further falling edges and closed after WIN_CYC.
- `busy` holds for ERASE_CYC-1 edges (CHIP_CYC-1 for a whole-array erase) and drops on the next one.
- After a suspend during the erase, the remaining count is ERASE_CYC minus the erase edges already taken, including the edge of the suspend write.

The bench sweeps every non-empty sector set. For each set it adds sectors in the last open cycle of the window, which checks that restart against the closing edge.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam int KEY_ABITS = 11;

    localparam logic [KEY_ABITS-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [KEY_ABITS-1:0] KEY_ADDR_B = 11'h2AA;

    localparam logic [7:0] CODE_KEY_A = 8'hAA;
    localparam logic [7:0] CODE_KEY_B = 8'h55;
    localparam logic [7:0] CODE_ARM   = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_SUSP  = 8'hB0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_KEY1,
        S_KEY2,
        S_ARMED,
        S_KEY3,
        S_KEY4,
        S_WINDOW,
        S_SECT_ERASE,
        S_CHIP_ERASE,
        S_SUSPEND
    } fes_state_e;

endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
    import fes_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              is_key_a,
    output logic              is_key_b,
    output logic              is_arm,
    output logic              is_chip,
    output logic              is_sect,
    output logic              is_susp,
    output logic [SECT_W-1:0] sector
);
    logic [KEY_ABITS-1:0] low_addr;
    logic [7:0]           code;

    always_comb begin
        low_addr = addr[KEY_ABITS-1:0];
        code     = data[7:0];
        is_key_a = (low_addr == KEY_ADDR_A) && (code == CODE_KEY_A);
        is_key_b = (low_addr == KEY_ADDR_B) && (code == CODE_KEY_B);
        is_arm   = (low_addr == KEY_ADDR_A) && (code == CODE_ARM);
        is_chip  = (low_addr == KEY_ADDR_A) && (code == CODE_CHIP);
        is_sect  = (code == CODE_SECT);
        is_susp  = (code == CODE_SUSP);
        sector   = addr[ADDR_W-1 -: SECT_W];
    end
endmodule

// File: rtl/fes_cycle_timer.sv
module fes_cycle_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign last = (cnt == limit - CNT_W'(1));
endmodule

// File: rtl/fes_sector_set.sv
module fes_sector_set #(
    parameter int NUM_SECT = 8,
    parameter int SECT_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                fill,
    input  logic                set,
    input  logic [SECT_W-1:0]   set_idx,
    output logic [NUM_SECT-1:0] mask
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask <= '0;
        end else if (fill) begin
            mask <= '1;
        end else if (set) begin
            mask[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int NUM_SECT  = 8,
    parameter int WIN_CYC   = 8,
    parameter int ERASE_CYC = 12,
    parameter int CHIP_CYC  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                busy,
    output logic                win_closed,
    output logic                suspended,
    output logic [NUM_SECT-1:0] sect_mask
);
    localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam int MAX_A   = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
    localparam int MAX_CYC = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fes_state_e state, nxt;

    logic              k_a, k_b, c_arm, c_chip, c_sect, c_susp;
    logic [SECT_W-1:0] sec_idx;
    logic              t_clr, t_en, t_last;
    logic [CNT_W-1:0]  t_limit;
    logic              m_clr, m_fill, m_set;

    fes_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_dec (
        .addr(wr_addr), .data(wr_data),
        .is_key_a(k_a), .is_key_b(k_b), .is_arm(c_arm), .is_chip(c_chip),
        .is_sect(c_sect), .is_susp(c_susp), .sector(sec_idx)
    );

    fes_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .en(t_en),
        .limit(t_limit), .last(t_last)
    );

    fes_sector_set #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_set (
        .clk(clk), .rst_n(rst_n), .clr(m_clr), .fill(m_fill),
        .set(m_set), .set_idx(sec_idx), .mask(sect_mask)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (wr_en && k_a) nxt = S_KEY1;
            S_KEY1:       if (wr_en) nxt = k_b   ? S_KEY2  : S_IDLE;
            S_KEY2:       if (wr_en) nxt = c_arm ? S_ARMED : S_IDLE;
            S_ARMED:      if (wr_en) nxt = k_a   ? S_KEY3  : S_IDLE;
            S_KEY3:       if (wr_en) nxt = k_b   ? S_KEY4  : S_IDLE;
            S_KEY4: begin
                if (wr_en) begin
                    if (c_chip)      nxt = S_CHIP_ERASE;
                    else if (c_sect) nxt = S_WINDOW;
                    else             nxt = S_IDLE;
                end
            end
            S_WINDOW: begin
                if (wr_en) begin
                    if (c_sect)      nxt = S_WINDOW;
                    else if (c_susp) nxt = S_SUSPEND;
                    else             nxt = S_IDLE;
                end else if (t_last) begin
                    nxt = S_SECT_ERASE;
                end
            end
            S_SECT_ERASE: begin
                if (wr_en && c_susp) nxt = S_SUSPEND;
                else if (t_last)     nxt = S_IDLE;
            end
            S_CHIP_ERASE: if (t_last) nxt = S_IDLE;
            S_SUSPEND:    if (wr_en && c_sect) nxt = S_SECT_ERASE;
            default:      nxt = S_IDLE;
        endcase
    end

    // timer and set control
    always_comb begin
        t_clr = (state == S_KEY4) ||
                ((state == S_WINDOW) && ((wr_en && c_sect) || (nxt != S_WINDOW)));
        t_en  = (state == S_WINDOW) || (state == S_SECT_ERASE) || (state == S_CHIP_ERASE);
        unique case (state)
            S_WINDOW:     t_limit = CNT_W'(WIN_CYC);
            S_CHIP_ERASE: t_limit = CNT_W'(CHIP_CYC);
            default:      t_limit = CNT_W'(ERASE_CYC);
        endcase
        m_clr  = (nxt == S_IDLE);
        m_fill = (state == S_KEY4) && wr_en && c_chip;
        m_set  = ((state == S_KEY4) || (state == S_WINDOW)) && wr_en && c_sect;
    end

    // outputs
    always_comb begin
        busy       = (state == S_SECT_ERASE) || (state == S_CHIP_ERASE);
        win_closed = busy || (state == S_SUSPEND);
        suspended  = (state == S_SUSPEND);
    end
endmodule

// File: rtl/fes_checker.sv
module fes_checker
    import fes_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 8,
    parameter int NUM_SECT = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                busy,
    input logic                win_closed,
    input logic                suspended,
    input logic [NUM_SECT-1:0] sect_mask
);
    localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

    logic              open_w;
    logic [7:0]        code;
    logic [SECT_W-1:0] idx;

    assign open_w = (sect_mask != '0) && !win_closed;
    assign code   = wr_data[7:0];
    assign idx    = wr_addr[ADDR_W-1 -: SECT_W];

    a_r4_sector_added: assert property (@(posedge clk) disable iff (!rst_n)
        open_w && wr_en && code == CODE_SECT |=> sect_mask[$past(idx)] && !win_closed);

    a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        open_w && wr_en && code != CODE_SECT && code != CODE_SUSP
        |=> sect_mask == '0 && !win_closed);

    a_r7_only_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en && code != CODE_SUSP |=> !suspended);

    a_r6_busy_has_set: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> win_closed && sect_mask != '0);

    a_r9_suspend_idle: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !busy && win_closed);

    a_r9_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && $past(suspended) |-> $stable(sect_mask));

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && !suspended |-> sect_mask == '0 && !win_closed);
endmodule

bind flash_erase_seq fes_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .win_closed(win_closed), .suspended(suspended), .sect_mask(sect_mask)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
    localparam int PERIOD = 10;
    localparam int AW = 12, DW = 8, NS = 8;
    localparam int WIN = 8, ERA = 12, CHP = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy, win_closed, suspended;
    logic [NS-1:0] sect_mask;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    flash_erase_seq #(
        .ADDR_W(AW), .DATA_W(DW), .NUM_SECT(NS),
        .WIN_CYC(WIN), .ERASE_CYC(ERA), .CHIP_CYC(CHP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .win_closed(win_closed), .suspended(suspended), .sect_mask(sect_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // packs busy, win_closed, suspended into 3 bits
    function automatic logic [31:0] st3();
        return {29'd0, busy, win_closed, suspended};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prefix();
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    endtask

    function automatic logic [AW-1:0] sa(input int s);
        return AW'(s) << (AW - 3);
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int first;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 status", st3(), 0);
        chk("R1 mask", 32'(sect_mask), 0);

        // R3 R4 R6: every non-empty set, sectors added in the last open cycle
        for (int m = 1; m < (1 << NS); m++) begin
            first = 0;
            for (int i = NS - 1; i >= 0; i--) if (m[i]) first = i;
            prefix();
            wr(sa(first), 8'h30);
            chk("R3 open", st3(), 0);
            for (int i = NS - 1; i >= 0; i--) begin
                if (m[i] && i != first) begin
                    tick(WIN - 1);
                    chk("R4 still open", st3(), 0);
                    wr(sa(i), 8'h30);
                end
            end
            chk("R4 set", 32'(sect_mask), 32'(m));
            tick(WIN - 1);
            chk("R3 window length", st3(), 0);
            tick(1);
            chk("R6 erase start", st3(), 3'b110);
            tick(ERA - 1);
            chk("R6 erase held", st3(), 3'b110);
            tick(1);
            chk("R6 erase end", st3(), 0);
            chk("R6 released", 32'(sect_mask), 0);
        end

        // R2 chip erase with upper address bits set, R7 writes ignored
        wr(12'hD55, 8'hAA); wr(12'hAAA, 8'h55); wr(12'hD55, 8'h80);
        wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55);
        wr(12'hD55, 8'h10);
        chk("R2 chip mask", 32'(sect_mask), 32'hFF);
        chk("R2 chip busy", st3(), 3'b110);
        wr(12'h000, 8'hB0);
        wr(12'h555, 8'hF0);
        chk("R7 chip ignores", st3(), 3'b110);
        chk("R7 chip mask", 32'(sect_mask), 32'hFF);
        tick(CHP - 3);
        chk("R2 chip held", st3(), 3'b110);
        tick(1);
        chk("R2 chip end", st3(), 0);
        chk("R2 chip released", 32'(sect_mask), 0);

        // R5 abort in window
        prefix();
        wr(sa(2), 8'h30);
        tick(3);
        wr(12'h555, 8'hF0);
        chk("R5 abort mask", 32'(sect_mask), 0);
        chk("R5 abort status", st3(), 0);
        tick(WIN + ERA);
        chk("R5 no erase later", st3(), 0);

        // R8 broken prefixes
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h54);
        wr(12'h555, 8'h80); wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
        wr(sa(4), 8'h30);
        chk("R8 bad key", 32'(sect_mask), 0);
        chk("R8 bad key status", st3(), 0);
        prefix();
        wr(12'h555, 8'h20);
        chk("R8 bad command", 32'(sect_mask), 0);
        wr(sa(1), 8'h30);
        chk("R8 needs new prefix", 32'(sect_mask), 0);
        tick(2);

        // R7 sector erase ignores non-suspend writes
        prefix();
        wr(sa(3), 8'h30);
        tick(WIN);
        wr(12'h555, 8'hF0);
        wr(sa(6), 8'h30);
        chk("R7 mask kept", 32'(sect_mask), 32'h08);
        chk("R7 still busy", st3(), 3'b110);
        tick(ERA - 3);
        chk("R7 held", st3(), 3'b110);
        tick(1);
        chk("R7 end", st3(), 0);

        // R9 suspend in window, resume runs full erase
        prefix();
        wr(sa(5), 8'h30);
        tick(2);
        wr(12'h123, 8'hB0);
        chk("R9 suspend in window", st3(), 3'b011);
        tick(30);
        wr(12'h555, 8'hF0);
        chk("R9 ignored while suspended", st3(), 3'b011);
        chk("R9 set kept", 32'(sect_mask), 32'h20);
        wr(12'h000, 8'h30);
        chk("R9 resumed", st3(), 3'b110);
        tick(ERA - 1);
        chk("R9 full erase held", st3(), 3'b110);
        tick(1);
        chk("R9 full erase end", st3(), 0);

        // R9 suspend mid-erase keeps remaining count
        prefix();
        wr(sa(1), 8'h30);
        tick(WIN);
        tick(4);
        wr(12'h7FF, 8'hB0);
        chk("R9 suspend in erase", st3(), 3'b011);
        tick(10);
        wr(12'h000, 8'h30);
        chk("R9 resumed mid", st3(), 3'b110);
        tick(ERA - 6);
        chk("R9 remaining held", st3(), 3'b110);
        tick(1);
        chk("R9 remaining end", st3(), 0);
        chk("R9 released", 32'(sect_mask), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule